// File: doc/BRIEF.md
# DC Bus Voltage Window Monitor

This block watches a digitized DC supply voltage and reports when it leaves a configured window. Each valid sample is compared with an undervoltage floor and an overvoltage ceiling. Each limit is chosen by a 3-bit code, and code 0 turns that direction off. The block raises a separate fault flag for each direction. It also drives an active-low combined fault line that a gate driver or a supervisor can use to stop switching.

Each direction runs its own small state machine. There are three states. ST_NORMAL means no fault. ST_TRIP_AUTO means the direction is faulted and will recover on its own. ST_TRIP_HELD means the direction is faulted and latched.

The transitions are as follows:
- normal-to-trip: a valid sample beyond the limit. The new state is ST_TRIP_AUTO when the direction's auto bit is 1 and ST_TRIP_HELD when it is 0.
- auto-recover (ST_TRIP_AUTO to ST_NORMAL): a valid sample that is back past the hysteresis band.
- auto-to-held: the auto bit drops to 0 while the direction is faulted.
- held-to-auto: the auto bit rises to 1 while the direction is faulted.
- held-clear (ST_TRIP_HELD to ST_NORMAL): a clear pulse while the most recent voltage is within bounds.
- disable: a threshold code of 0 sends the state machine to ST_NORMAL from any state.

The hysteresis width differs between the two directions and has a select bit that doubles it.

Top module: `vbus_window_mon`

## Requirements
- R1: After reset both fault flags are 0 and `fault_n_o` is 1.
- R2: The undervoltage code maps to a floor in 10 mV units: 1→500, 2→600, 3→700, 4→800, 5→1000, 6→1200, 7→1500. On the clock edge of a valid sample strictly below the floor, `uv_fault_o` becomes 1. A sample equal to the floor does not set it.
- R3: The overvoltage code maps to a ceiling in 10 mV units: 1→1000, 2→1500, 3→2200, 4→3200, 5→4000, 6→5000, 7→6000. On the clock edge of a valid sample strictly above the ceiling, `ov_fault_o` becomes 1. A sample equal to the ceiling does not set it.
- R4: A code of 0 disables its direction. Such a direction never sets, and a set flag of that direction clears on the next edge.
- R5: With `uv_auto_i`=1, an undervoltage fault clears on a valid sample at or above the floor plus the hysteresis. The hysteresis is 50 with `hys_wide_i`=0 and 100 with `hys_wide_i`=1. Samples inside the band keep the fault.
- R6: With `ov_auto_i`=1, an overvoltage fault clears on a valid sample at or below the ceiling minus the hysteresis. The hysteresis is 100 with `hys_wide_i`=0 and 200 with `hys_wide_i`=1. Samples inside the band keep the fault.
- R7: With the auto bit 0, a fault stays set whatever the later samples are, as long as no clear pulse is seen.
- R8: A held fault clears on an edge where `clr_i`=1 only if the latest voltage is within bounds. The latest voltage is the same-cycle sample when it is valid, otherwise the last valid sample. Within bounds means not below the floor for undervoltage and not above the ceiling for overvoltage. A clear pulse has no effect on the other direction while that direction is out of bounds.
- R9: A sample with `vs_valid_i`=0 changes no flag.
- R10: `fault_n_o` is 0 exactly when at least one fault flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vs_valid_i | input | 1 | Sample strobe |
| vs_data_i | input | 16 | Voltage sample, unsigned, 10 mV units |
| uv_code_i | input | 3 | Undervoltage floor code, 0 = off |
| ov_code_i | input | 3 | Overvoltage ceiling code, 0 = off |
| uv_auto_i | input | 1 | Undervoltage recovery: 1 auto, 0 held |
| ov_auto_i | input | 1 | Overvoltage recovery: 1 auto, 0 held |
| hys_wide_i | input | 1 | Hysteresis select: 1 doubles the band |
| clr_i | input | 1 | Clear pulse for held faults |
| uv_fault_o | output | 1 | Undervoltage fault flag |
| ov_fault_o | output | 1 | Overvoltage fault flag |
| fault_n_o | output | 1 | Active-low combined fault |

## Verification
Every nonzero code is swept with samples exactly at the limit, one count past it and exactly at the recovery level. This separates off-by-one comparisons and a wrong table entry from a wrong hysteresis. Walks through the band with both hysteresis widths show the two widths apart and show the two directions' bands apart. Held-mode sequences apply clear pulses after an out-of-bounds sample, after a sample exactly at the floor and after an in-bounds one. A sequence with both flags set at once shows that a clear pulse acts per direction. Strobe-low samples and code-0 configurations confirm that the ignored inputs and the disabled directions leave the flags untouched or cleared.

// File: rtl/vbus_pkg.sv
`timescale 1ns/1ps
package vbus_pkg;

    typedef enum logic [1:0] {
        ST_NORMAL    = 2'd0,
        ST_TRIP_AUTO = 2'd1,
        ST_TRIP_HELD = 2'd2
    } trip_state_e;

    localparam int unsigned NUM_DIRS = 2;
    localparam int unsigned DIR_UNDER = 0;
    localparam int unsigned DIR_OVER  = 1;

endpackage

// File: rtl/vbus_limit_map.sv
`timescale 1ns/1ps
// Maps a threshold code and the hysteresis select to a limit level and band
// width in sample units. IS_OVER picks the overvoltage table.
module vbus_limit_map #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CODE_W = 3,
    parameter int unsigned LSB_MV = 10,
    parameter bit          IS_OVER = 1'b0
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic              hys_wide_i,
    output logic              enable_o,
    output logic [DATA_W-1:0] limit_o,
    output logic [DATA_W-1:0] hyst_o
);

    localparam int unsigned UV_HYS_N = 500  / LSB_MV;
    localparam int unsigned UV_HYS_W = 1000 / LSB_MV;
    localparam int unsigned OV_HYS_N = 1000 / LSB_MV;
    localparam int unsigned OV_HYS_W = 2000 / LSB_MV;

    function automatic int unsigned uv_floor_mv(input logic [CODE_W-1:0] c);
        unique case (c)
            3'd1:    return 5000;
            3'd2:    return 6000;
            3'd3:    return 7000;
            3'd4:    return 8000;
            3'd5:    return 10000;
            3'd6:    return 12000;
            3'd7:    return 15000;
            default: return 0;
        endcase
    endfunction

    function automatic int unsigned ov_ceil_mv(input logic [CODE_W-1:0] c);
        unique case (c)
            3'd1:    return 10000;
            3'd2:    return 15000;
            3'd3:    return 22000;
            3'd4:    return 32000;
            3'd5:    return 40000;
            3'd6:    return 50000;
            3'd7:    return 60000;
            default: return 0;
        endcase
    endfunction

    int unsigned level_mv;
    int unsigned band;

    generate
        if (IS_OVER) begin : g_over
            always_comb begin
                level_mv = ov_ceil_mv(code_i);
                band     = hys_wide_i ? OV_HYS_W : OV_HYS_N;
            end
        end else begin : g_under
            always_comb begin
                level_mv = uv_floor_mv(code_i);
                band     = hys_wide_i ? UV_HYS_W : UV_HYS_N;
            end
        end
    endgenerate

    int unsigned level_lsb;
    assign level_lsb = level_mv / LSB_MV;

    assign enable_o = (code_i != '0);
    assign limit_o  = level_lsb[DATA_W-1:0];
    assign hyst_o   = band[DATA_W-1:0];

endmodule

// File: rtl/vbus_dir_fsm.sv
`timescale 1ns/1ps
// One direction of the window: compare, state register and flag output.
module vbus_dir_fsm
    import vbus_pkg::*;
#(
    parameter int unsigned DATA_W  = 16,
    parameter bit          IS_OVER = 1'b0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              enable_i,
    input  logic [DATA_W-1:0] limit_i,
    input  logic [DATA_W-1:0] hyst_i,
    input  logic              auto_i,
    input  logic              clr_i,
    output logic              fault_o
);

    localparam int unsigned EXT_W = DATA_W + 1;

    trip_state_e state_q, state_d;
    logic        ok_q;

    logic [EXT_W-1:0] data_x;
    logic [EXT_W-1:0] lim_x;
    logic [EXT_W-1:0] rec_lvl;
    logic             beyond;
    logic             back;
    logic             hit;
    logic             ok_now;

    assign data_x = {1'b0, data_i};
    assign lim_x  = {1'b0, limit_i};

    generate
        if (IS_OVER) begin : g_over_cmp
            assign rec_lvl = lim_x - {1'b0, hyst_i};
            assign beyond  = data_x > lim_x;
            assign back    = data_x <= rec_lvl;
        end else begin : g_under_cmp
            assign rec_lvl = lim_x + {1'b0, hyst_i};
            assign beyond  = data_x < lim_x;
            assign back    = data_x >= rec_lvl;
        end
    endgenerate

    assign hit    = valid_i && beyond;
    assign ok_now = valid_i ? !beyond : ok_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NORMAL: begin
                if (hit) begin
                    state_d = auto_i ? ST_TRIP_AUTO : ST_TRIP_HELD;
                end
            end
            ST_TRIP_AUTO: begin
                if (!auto_i) begin
                    state_d = ST_TRIP_HELD;
                end else if (valid_i && back) begin
                    state_d = ST_NORMAL;
                end
            end
            ST_TRIP_HELD: begin
                if (auto_i) begin
                    state_d = ST_TRIP_AUTO;
                end else if (clr_i && ok_now) begin
                    state_d = ST_NORMAL;
                end
            end
            default: state_d = ST_NORMAL;
        endcase
        if (!enable_i) begin
            state_d = ST_NORMAL;
        end
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_NORMAL;
            ok_q    <= 1'b1;
        end else begin
            state_q <= state_d;
            if (valid_i) begin
                ok_q <= !beyond;
            end
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            ST_TRIP_AUTO: fault_o = 1'b1;
            ST_TRIP_HELD: fault_o = 1'b1;
            default:      fault_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/vbus_window_mon.sv
`timescale 1ns/1ps
module vbus_window_mon
    import vbus_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CODE_W = 3,
    parameter int unsigned LSB_MV = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              vs_valid_i,
    input  logic [DATA_W-1:0] vs_data_i,
    input  logic [CODE_W-1:0] uv_code_i,
    input  logic [CODE_W-1:0] ov_code_i,
    input  logic              uv_auto_i,
    input  logic              ov_auto_i,
    input  logic              hys_wide_i,
    input  logic              clr_i,
    output logic              uv_fault_o,
    output logic              ov_fault_o,
    output logic              fault_n_o
);

    logic [CODE_W-1:0] code_w [NUM_DIRS];
    logic              auto_w [NUM_DIRS];
    logic              en_w   [NUM_DIRS];
    logic [DATA_W-1:0] lim_w  [NUM_DIRS];
    logic [DATA_W-1:0] hys_w  [NUM_DIRS];
    logic              flt_w  [NUM_DIRS];

    assign code_w[DIR_UNDER] = uv_code_i;
    assign code_w[DIR_OVER]  = ov_code_i;
    assign auto_w[DIR_UNDER] = uv_auto_i;
    assign auto_w[DIR_OVER]  = ov_auto_i;

    for (genvar g = 0; g < NUM_DIRS; g++) begin : g_dir
        vbus_limit_map #(
            .DATA_W (DATA_W),
            .CODE_W (CODE_W),
            .LSB_MV (LSB_MV),
            .IS_OVER(g == DIR_OVER)
        ) u_map (
            .code_i    (code_w[g]),
            .hys_wide_i(hys_wide_i),
            .enable_o  (en_w[g]),
            .limit_o   (lim_w[g]),
            .hyst_o    (hys_w[g])
        );

        vbus_dir_fsm #(
            .DATA_W (DATA_W),
            .IS_OVER(g == DIR_OVER)
        ) u_fsm (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .valid_i (vs_valid_i),
            .data_i  (vs_data_i),
            .enable_i(en_w[g]),
            .limit_i (lim_w[g]),
            .hyst_i  (hys_w[g]),
            .auto_i  (auto_w[g]),
            .clr_i   (clr_i),
            .fault_o (flt_w[g])
        );
    end

    logic [DATA_W-1:0] uv_lim;
    logic [DATA_W-1:0] ov_lim;
    assign uv_lim = lim_w[DIR_UNDER];
    assign ov_lim = lim_w[DIR_OVER];

    assign uv_fault_o = flt_w[DIR_UNDER];
    assign ov_fault_o = flt_w[DIR_OVER];
    assign fault_n_o  = !(flt_w[DIR_UNDER] || flt_w[DIR_OVER]);

endmodule

// File: rtl/vbus_window_mon_chk.sv
`timescale 1ns/1ps
module vbus_window_mon_chk #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CODE_W = 3
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              vs_valid_i,
    input logic [DATA_W-1:0] vs_data_i,
    input logic [CODE_W-1:0] uv_code_i,
    input logic [CODE_W-1:0] ov_code_i,
    input logic              uv_auto_i,
    input logic              ov_auto_i,
    input logic              clr_i,
    input logic              uv_fault_o,
    input logic              ov_fault_o,
    input logic [DATA_W-1:0] uv_lim,
    input logic [DATA_W-1:0] ov_lim
);

    p_reset_clear_r1: assert property (@(posedge clk_i)
        !rst_ni |=> (!uv_fault_o && !ov_fault_o));

    p_uv_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vs_valid_i && uv_code_i != '0 && vs_data_i < uv_lim) |=> uv_fault_o);

    p_ov_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vs_valid_i && ov_code_i != '0 && vs_data_i > ov_lim) |=> ov_fault_o);

    p_uv_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (uv_code_i == '0) |=> !uv_fault_o);

    p_ov_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ov_code_i == '0) |=> !ov_fault_o);

    p_uv_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (uv_fault_o && !clr_i && !uv_auto_i && uv_code_i != '0) |=> uv_fault_o);

    p_ov_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ov_fault_o && !clr_i && !ov_auto_i && ov_code_i != '0) |=> ov_fault_o);

    p_uv_novalid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!vs_valid_i && !clr_i && uv_code_i != '0 && $stable(uv_auto_i)) |=> $stable(uv_fault_o));

    p_ov_novalid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!vs_valid_i && !clr_i && ov_code_i != '0 && $stable(ov_auto_i)) |=> $stable(ov_fault_o));

endmodule

bind vbus_window_mon vbus_window_mon_chk #(
    .DATA_W(DATA_W),
    .CODE_W(CODE_W)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vs_valid_i(vs_valid_i),
    .vs_data_i (vs_data_i),
    .uv_code_i (uv_code_i),
    .ov_code_i (ov_code_i),
    .uv_auto_i (uv_auto_i),
    .ov_auto_i (ov_auto_i),
    .clr_i     (clr_i),
    .uv_fault_o(uv_fault_o),
    .ov_fault_o(ov_fault_o),
    .uv_lim    (uv_lim),
    .ov_lim    (ov_lim)
);

// File: tb/vbus_window_mon_bench.sv
`timescale 1ns/1ps
module vbus_window_mon_bench;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        vs_valid_i = 1'b0;
    logic [15:0] vs_data_i = '0;
    logic [2:0]  uv_code_i = '0;
    logic [2:0]  ov_code_i = '0;
    logic        uv_auto_i = 1'b0;
    logic        ov_auto_i = 1'b0;
    logic        hys_wide_i = 1'b0;
    logic        clr_i = 1'b0;
    logic        uv_fault_o, ov_fault_o, fault_n_o;

    always #2.5 clk_i = !clk_i;

    vbus_window_mon u_vbus_window_mon (
        .clk_i, .rst_ni, .vs_valid_i, .vs_data_i, .uv_code_i, .ov_code_i,
        .uv_auto_i, .ov_auto_i, .hys_wide_i, .clr_i,
        .uv_fault_o, .ov_fault_o, .fault_n_o
    );

    typedef struct {
        logic  euv;
        logic  eov;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    function automatic int floor_of(int c);
        case (c)
            1: return 500;   2: return 600;   3: return 700;  4: return 800;
            5: return 1000;  6: return 1200;  default: return 1500;
        endcase
    endfunction

    function automatic int ceil_of(int c);
        case (c)
            1: return 1000;  2: return 1500;  3: return 2200; 4: return 3200;
            5: return 4000;  6: return 5000;  default: return 6000;
        endcase
    endfunction

    task automatic cfg(input int uc, input int oc, input bit ua, input bit oa, input bit hw);
        @(negedge clk_i);
        uv_code_i  = 3'(uc);
        ov_code_i  = 3'(oc);
        uv_auto_i  = ua;
        ov_auto_i  = oa;
        hys_wide_i = hw;
        vs_valid_i = 1'b0;
        clr_i      = 1'b0;
    endtask

    task automatic step(input bit v, input int d, input bit c,
                        input logic euv, input logic eov, input string tag);
        exp_t e;
        @(negedge clk_i);
        vs_valid_i = v;
        vs_data_i  = 16'(d);
        clr_i      = c;
        e.euv = euv;
        e.eov = eov;
        e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compares one result per edge after the outputs settle
    initial begin
        forever begin
            @(posedge clk_i);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_vec++;
                if (uv_fault_o !== e.euv || ov_fault_o !== e.eov ||
                    fault_n_o !== !(e.euv || e.eov)) begin
                    n_bad++;
                    $display("FAIL %s: uv/ov/n = %b%b%b expected %b%b%b", e.tag,
                             uv_fault_o, ov_fault_o, fault_n_o,
                             e.euv, e.eov, !(e.euv || e.eov));
                end
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        rst_ni = 1'b1;
        // R1 reset state
        step(0, 0, 0, 0, 0, "R1 reset");
        // R4 both directions off
        step(1, 0, 0, 0, 0, "R4 uv off");
        step(1, 65535, 0, 0, 0, "R4 ov off");

        // R2/R5 undervoltage auto, narrow band
        cfg(4, 0, 1, 0, 0);
        step(1, 800, 0, 0, 0, "R2 equal floor");
        step(1, 799, 0, 1, 0, "R2 below floor");
        step(1, 849, 0, 1, 0, "R5 inside band");
        step(0, 2000, 0, 1, 0, "R9 strobe low");
        step(1, 850, 0, 0, 0, "R5 recover narrow");
        // R5 wide band
        cfg(4, 0, 1, 0, 1);
        step(1, 700, 0, 1, 0, "R2 set");
        step(1, 899, 0, 1, 0, "R5 inside wide band");
        step(1, 900, 0, 0, 0, "R5 recover wide");

        // R3/R6 overvoltage auto
        cfg(0, 3, 0, 1, 0);
        step(1, 2200, 0, 0, 0, "R3 equal ceiling");
        step(1, 2201, 0, 0, 1, "R3 above ceiling");
        step(1, 2101, 0, 0, 1, "R6 inside band");
        step(1, 2100, 0, 0, 0, "R6 recover narrow");
        cfg(0, 3, 0, 1, 1);
        step(1, 3000, 0, 0, 1, "R3 set");
        step(1, 2001, 0, 0, 1, "R6 inside wide band");
        step(1, 2000, 0, 0, 0, "R6 recover wide");

        // R7/R8 held undervoltage
        cfg(5, 0, 0, 0, 0);
        step(1, 999, 0, 1, 0, "R2 held set");
        step(1, 1500, 0, 1, 0, "R7 held despite recovery");
        step(0, 0, 1, 0, 0, "R8 clear in bounds");
        step(1, 900, 0, 1, 0, "R2 held set again");
        step(0, 0, 1, 1, 0, "R8 clear refused out of bounds");
        step(1, 1000, 0, 1, 0, "R7 held at floor");
        step(0, 0, 1, 0, 0, "R8 clear at floor");
        step(1, 900, 0, 1, 0, "R2 held set third");
        step(1, 1200, 1, 0, 0, "R8 clear with same-cycle sample");

        // R8/R10 both held, per-direction clear
        cfg(5, 3, 0, 0, 0);
        step(1, 950, 0, 1, 0, "R2 uv held");
        step(1, 2300, 0, 1, 1, "R10 both set");
        step(0, 0, 1, 0, 1, "R8 clear uv only");
        step(1, 1500, 0, 0, 1, "R7 ov held");
        step(0, 0, 1, 0, 0, "R8 clear ov");
        step(0, 0, 1, 0, 0, "R8 clear without fault");

        // R4 disabling clears a set flag
        step(1, 2300, 0, 0, 1, "R3 ov held");
        cfg(5, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, "R4 disable clears ov");

        // R2/R5 sweep of undervoltage codes
        for (int c = 1; c <= 7; c++) begin
            cfg(c, 0, 1, 0, 0);
            step(1, floor_of(c), 0, 0, 0, "R2 sweep equal");
            step(1, floor_of(c) - 1, 0, 1, 0, "R2 sweep below");
            step(1, floor_of(c) + 49, 0, 1, 0, "R5 sweep band");
            step(1, floor_of(c) + 50, 0, 0, 0, "R5 sweep recover");
        end
        // R3/R6 sweep of overvoltage codes
        for (int c = 1; c <= 7; c++) begin
            cfg(0, c, 0, 1, 0);
            step(1, ceil_of(c), 0, 0, 0, "R3 sweep equal");
            step(1, ceil_of(c) + 1, 0, 0, 1, "R3 sweep above");
            step(1, ceil_of(c) - 99, 0, 0, 1, "R6 sweep band");
            step(1, ceil_of(c) - 100, 0, 0, 0, "R6 sweep recover");
        end

        @(negedge clk_i);
        vs_valid_i = 1'b0;
        clr_i = 1'b0;
        repeat (4) @(posedge clk_i);
        #2;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule